// File: doc/BRIEF.md
# Standby Bus Wake-Up Detector

This block runs beside a bus transceiver that is in its low-power state. It takes a synchronous, already-sampled "bus is dominant" bit from a wake-up comparator. It drives the receive-data line back to the host low to request a wake-up. A request is raised only for a genuine wake-up: the detector must first see the bus move from recessive to dominant while standby is active. The bus must then stay dominant for more than `T_WAKE` sampled cycles.

A second limit, `T_TO_BUS`, guards against a bus that is clamped dominant by a short circuit or a faulty node. Once an unbroken dominant run grows beyond that many samples, the line is released high again. It stays high until the bus has gone recessive and a fresh recessive-to-dominant edge starts a new run. Both limits count clock cycles, and the run counter saturates so it cannot wrap. `wake_flag` marks the first cycle of each request with a single-cycle pulse. Leaving standby clears all state and releases the line.

Top module: `bus_wake_detector`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `rxd` is 1 and `wake_flag` is 0.
- R2: Only a recessive-to-dominant change that is sampled while `standby_active` is 1 starts a run. A bus that is dominant when standby begins does not start one, and neither does a bus that turns dominant in the first standby cycle. Such a bus must first go recessive.
- R3: Let a run start at the edge where the first dominant sample is taken. If the bus stays dominant for at least `T_WAKE`+1 samples, `rxd` goes low after the edge that follows the (`T_WAKE`+1)-th dominant sample.
- R4: A dominant run of `T_WAKE` samples or fewer leaves `rxd` at 1. The next run is timed from zero, so two short runs separated by one recessive sample never add up to a wake-up.
- R5: For an uninterrupted run of L dominant samples, `rxd` is low for exactly max(0, min(L, `T_TO_BUS`) − `T_WAKE`) cycles. Dominance lasting beyond `T_TO_BUS` samples returns `rxd` to 1 while the bus is still dominant.
- R6: A single recessive sample clears the run. After a timeout, a new recessive-to-dominant edge can raise a new request.
- R7: If `standby_active` is 0 at an edge, `rxd` is 1 after that edge and the run is discarded. Dominance that carries over when standby is re-entered does not wake.
- R8: `wake_flag` is 1 for exactly one cycle: the cycle in which `rxd` is first low in a request. It is 0 at all other times.
- R9: The run counter saturates at `T_TO_BUS`+1 and holds there while the bus stays dominant in standby, so a clamped bus never restarts the wake window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_active | input | 1 | 1 while the transceiver is in standby; the detector runs only then |
| bus_dom | input | 1 | Synchronised comparator output, 1 = bus dominant |
| rxd | output | 1 | Wake-up indication to the host, low = request |
| wake_flag | output | 1 | One-cycle pulse on the first low cycle of `rxd` |

## Verification
Several situations cannot be reached by holding the bus at one level. The first is leaving standby while a request is already asserted. The second is re-entering standby with the bus still dominant. The third is the timeout followed by a new wake-up. The stimulus reaches them in sequence: it lets a run pass `T_WAKE` and drops `standby_active` mid-request. It then keeps the bus dominant across the re-entry, and only after that lets the bus go recessive for one sample before starting a fresh run. Small limits (4 and 12) keep every run length around both thresholds short enough to sweep exhaustively.

// File: rtl/bwu_pkg.sv
package bwu_pkg;

    typedef struct packed {
        logic prev_dom;
    } edge_state_t;

    typedef struct packed {
        logic        running;
        logic [31:0] count;
    } timer_state_t;

    typedef struct packed {
        logic rxd;
        logic flag;
    } out_state_t;

endpackage

// File: rtl/bwu_edge_detect.sv
module bwu_edge_detect
    import bwu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic standby_active,
    input  logic bus_dom,
    output logic rise
);

    edge_state_t st_d, st_q;

    // Outside standby the previous level is held dominant, so that a bus
    // which is already dominant on entry produces no edge.
    always_comb begin
        st_d          = st_q;
        st_d.prev_dom = standby_active ? bus_dom : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev_dom: 1'b1};
        else        st_q <= st_d;
    end

    assign rise = standby_active && bus_dom && !st_q.prev_dom;

endmodule

// File: rtl/bwu_dom_timer.sv
module bwu_dom_timer
    import bwu_pkg::*;
#(
    parameter int unsigned T_TO_BUS = 100000,
    localparam int unsigned SAT     = T_TO_BUS + 1,
    localparam int unsigned CW      = $clog2(SAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby_active,
    input  logic          bus_dom,
    input  logic          rise,
    output logic          running,
    output logic [CW-1:0] count
);

    timer_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!standby_active || !bus_dom) begin
            st_d.running = 1'b0;
            st_d.count   = '0;
        end else if (rise) begin
            st_d.running = 1'b1;
            st_d.count   = 32'd1;
        end else if (st_q.running && st_q.count < 32'(SAT)) begin
            st_d.count = st_q.count + 32'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{running: 1'b0, count: '0};
        else        st_q <= st_d;
    end

    assign running = st_q.running;
    assign count   = st_q.count[CW-1:0];

endmodule

// File: rtl/bwu_rxd_gen.sv
module bwu_rxd_gen
    import bwu_pkg::*;
#(
    parameter int unsigned T_WAKE   = 200,
    parameter int unsigned T_TO_BUS = 100000,
    localparam int unsigned CW      = $clog2(T_TO_BUS + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby_active,
    input  logic          running,
    input  logic [CW-1:0] count,
    output logic          rxd,
    output logic          wake_flag
);

    out_state_t st_d, st_q;
    logic       in_window;

    always_comb begin
        in_window = running
                 && (32'(count) > T_WAKE)
                 && (32'(count) <= T_TO_BUS);
        st_d      = st_q;
        st_d.rxd  = !(standby_active && in_window);
        st_d.flag = st_q.rxd && !st_d.rxd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{rxd: 1'b1, flag: 1'b0};
        else        st_q <= st_d;
    end

    assign rxd       = st_q.rxd;
    assign wake_flag = st_q.flag;

endmodule

// File: rtl/bus_wake_detector.sv
module bus_wake_detector #(
    parameter int unsigned T_WAKE   = 200,
    parameter int unsigned T_TO_BUS = 100000,
    localparam int unsigned CW      = $clog2(T_TO_BUS + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby_active,
    input  logic bus_dom,
    output logic rxd,
    output logic wake_flag
);

    logic          rise;
    logic          running;
    logic [CW-1:0] dom_cnt;

    bwu_edge_detect u_edge (
        .clk            (clk),
        .rst_n          (rst_n),
        .standby_active (standby_active),
        .bus_dom        (bus_dom),
        .rise           (rise)
    );

    bwu_dom_timer #(.T_TO_BUS(T_TO_BUS)) u_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .standby_active (standby_active),
        .bus_dom        (bus_dom),
        .rise           (rise),
        .running        (running),
        .count          (dom_cnt)
    );

    bwu_rxd_gen #(.T_WAKE(T_WAKE), .T_TO_BUS(T_TO_BUS)) u_out (
        .clk            (clk),
        .rst_n          (rst_n),
        .standby_active (standby_active),
        .running        (running),
        .count          (dom_cnt),
        .rxd            (rxd),
        .wake_flag      (wake_flag)
    );

endmodule

// File: rtl/bus_wake_detector_chk.sv
module bus_wake_detector_chk #(
    parameter int unsigned T_TO_BUS = 100000,
    localparam int unsigned CW      = $clog2(T_TO_BUS + 2)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          standby_active,
    input logic          bus_dom,
    input logic          rxd,
    input logic          wake_flag,
    input logic [CW-1:0] dom_cnt
);

    AST_RELEASE_OUTSIDE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_active |=> rxd); // R7

    AST_NO_FLAG_OUTSIDE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_active |=> !wake_flag); // R7

    AST_FLAG_MARKS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        wake_flag |-> (!rxd && $past(rxd))); // R8

    AST_FALL_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rxd) |-> wake_flag); // R8

    AST_SATURATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(dom_cnt) == T_TO_BUS + 1 && bus_dom && standby_active)
        |=> (32'(dom_cnt) == T_TO_BUS + 1)); // R9

    AST_CLEAR_ON_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_dom |=> dom_cnt == '0); // R6

endmodule

bind bus_wake_detector bus_wake_detector_chk #(.T_TO_BUS(T_TO_BUS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .standby_active (standby_active),
    .bus_dom        (bus_dom),
    .rxd            (rxd),
    .wake_flag      (wake_flag),
    .dom_cnt        (dom_cnt)
);

// File: tb/bus_wake_detector_tb_top.sv
module bus_wake_detector_tb_top;

    localparam int unsigned TW  = 4;
    localparam int unsigned TTO = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standby_active = 1'b0;
    logic bus_dom = 1'b0;
    logic rxd, wake_flag;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bus_wake_detector #(.T_WAKE(TW), .T_TO_BUS(TTO)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .standby_active (standby_active),
        .bus_dom        (bus_dom),
        .rxd            (rxd),
        .wake_flag      (wake_flag)
    );

    typedef struct packed {
        logic        sb;
        logic [31:0] len;
        logic [31:0] exp_low;
        logic [31:0] exp_flags;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'd1,  32'd0, 32'd0},   // R4
        '{1'b1, 32'd4,  32'd0, 32'd0},   // R4 boundary
        '{1'b1, 32'd5,  32'd1, 32'd1},   // R3 boundary
        '{1'b1, 32'd8,  32'd4, 32'd1},   // R3
        '{1'b1, 32'd12, 32'd8, 32'd1},   // R5 boundary
        '{1'b1, 32'd13, 32'd8, 32'd1},   // R5
        '{1'b1, 32'd30, 32'd8, 32'd1},   // R5 clamped
        '{1'b0, 32'd8,  32'd0, 32'd0},   // R7
        '{1'b1, 32'd6,  32'd2, 32'd1}    // R6 new edge
    };

    logic prev_rxd = 1'b1;
    int   lows, flags;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, sample just after posedge
    task automatic step(input logic sb, input logic dom);
        @(negedge clk);
        standby_active = sb;
        bus_dom        = dom;
        @(posedge clk);
        #1;
        if (!rxd) lows++;
        if (wake_flag) flags++;
        if (wake_flag !== (prev_rxd && !rxd)) begin
            check(1'b0, "R8 flag/fall", int'(wake_flag), int'(prev_rxd && !rxd));
        end
        prev_rxd = rxd;
    endtask

    task automatic run(input logic sb, input int len, input int pre);
        lows = 0; flags = 0;
        for (int i = 0; i < pre; i++) step(sb, 1'b0);
        for (int i = 0; i < len; i++) step(sb, 1'b1);
        for (int i = 0; i < 4; i++) step(sb, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        check(rxd === 1'b1 && wake_flag === 1'b0, "R1 reset", int'(rxd), 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(rxd === 1'b1 && wake_flag === 1'b0, "R1 after reset", int'(rxd), 1);

        // table walk
        for (int v = 0; v < NV; v++) begin
            run(VECS[v].sb, int'(VECS[v].len), 3);
            check(lows == int'(VECS[v].exp_low), $sformatf("R5 low cycles len=%0d", VECS[v].len),
                  lows, int'(VECS[v].exp_low));
            check(flags == int'(VECS[v].exp_flags), $sformatf("R8 flag count len=%0d", VECS[v].len),
                  flags, int'(VECS[v].exp_flags));
        end

        // R3 exact latency: 5 dominant samples -> low only after the next edge
        lows = 0;
        step(1'b1, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1);
        check(rxd === 1'b1, "R3 not yet low", int'(rxd), 1);
        step(1'b1, 1'b1);
        check(rxd === 1'b0 && wake_flag === 1'b1, "R3 low after next edge", int'(rxd), 0);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);

        // R2: bus dominant before standby is entered
        lows = 0; flags = 0;
        step(1'b0, 1'b1);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1);
        check(lows == 0, "R2 dominant at entry", lows, 0);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);

        // R4: two short runs split by one recessive sample
        lows = 0;
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        check(lows == 0, "R4 no accumulation", lows, 0);

        // R7: leave standby mid-request, re-enter with bus still dominant
        lows = 0;
        for (int i = 0; i < 7; i++) step(1'b1, 1'b1);
        check(rxd === 1'b0, "R7 request active", int'(rxd), 0);
        step(1'b0, 1'b1);
        check(rxd === 1'b1, "R7 released on exit", int'(rxd), 1);
        lows = 0;
        for (int i = 0; i < 15; i++) step(1'b1, 1'b1);
        check(lows == 0, "R7 carried dominance ignored", lows, 0);

        // R6/R9: after a clamp, one recessive sample re-arms
        lows = 0; flags = 0;
        for (int i = 0; i < 30; i++) step(1'b1, 1'b1);
        check(lows == 0 && rxd === 1'b1, "R9 clamp stays high", lows, 0);
        step(1'b1, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        check(lows == 2, "R6 re-armed low cycles", lows, 2);
        check(flags == 1, "R8 re-armed flag", flags, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule